// File: doc/BRIEF.md
# Reference Switch Hitless Controller

This block handles the digital side of a reference change in a clock PLL. Once the loop reports lock, the controller arms. Two events then trigger it: a change on the reference-select input, or a phase-detector sample whose magnitude exceeds a large-step threshold. When triggered, it asks the analog loop for a narrow bandwidth. It also moves the feedback edge index by the whole number of oscillator periods nearest the measured step. In this way most of the phase jump is cancelled by choosing a different oscillator edge, and the loop does not have to slew through it.

After the edge move, later phase samples are corrected by the offset just applied. Once the corrected error has stayed inside a small window for a run of consecutive valid samples, the narrow-bandwidth request is released and the controller arms again. The oscillator period, both thresholds and the run length are parameters. The phase samples come from an external time-to-digital converter, in picoseconds.

Top module: `ref_switch_ctrl`

## Requirements
- R1: After reset the block is disarmed (`armed`=0, `active`=0), `edge_ofs` is 0 and `narrow_bw` is 0.
- R2: While disarmed, the block moves to armed one clock after `pll_lock` is sampled high. While `pll_lock` is low it stays disarmed, and neither reference changes nor phase steps trigger it.
- R3: While armed, a clock in which `ref_sel` differs from its value sampled on the previous clock makes the block active on the next clock.
- R4: While armed, a valid sample whose magnitude is strictly above TRIG_PS (4000 ps) makes the block active on the next clock. A magnitude of exactly 4000 ps does not trigger.
- R5: `narrow_bw` and `active` are high on exactly the same clocks, and `armed` and `active` are never both high.
- R6: The first valid sample at or after the trigger selects the new edge. Let delta be that sample divided by PERIOD_PS (1608 ps) and rounded to the nearest integer, with halves rounded away from zero. Then `edge_ofs` becomes (`edge_ofs` + delta) modulo M, taken in the range 0..M-1. M is `fb_div`, and a value of 0 counts as 1.
- R7: After the edge selection, each valid sample is corrected to sample − delta×PERIOD_PS. A corrected magnitude of at most SETTLE_PS (2000 ps, inclusive) counts toward a run, and one above it restarts the run. Clocks with no valid sample leave the run unchanged. The valid sample that completes a run of SETTLE_N (8) returns the block to armed on the next clock.
- R8: While active, reference changes and large steps are ignored: `edge_ofs` keeps its value and the run is not restarted by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_err | input | PHASE_W (24) | Signed phase error sample, picoseconds |
| phase_vld | input | 1 | Sample valid strobe |
| pll_lock | input | 1 | Loop lock indicator |
| ref_sel | input | 1 | Reference select level |
| fb_div | input | M_W (9) | Feedback divider value M |
| narrow_bw | output | 1 | Request for narrow loop bandwidth |
| edge_ofs | output | M_W (9) | Feedback oscillator edge index |
| armed | output | 1 | Block armed and waiting for a trigger |
| active | output | 1 | Switch event in progress |

## Verification
The bench probes each threshold exactly at its edge. A 4000 ps step must not trigger, and a 4001 ps step must trigger. A residual of exactly 2000 ps must still count toward the run; a comparator with a strict limit would never settle. It also drives steps of exactly half a period in both signs, where a round-toward-zero divider lands one edge short. It uses negative steps that must wrap to the top of the 0..M-1 range, and it changes M so that a wrap against a stale modulus shows up in `edge_ofs`. An invalid clock is placed inside a run, and an out-of-window sample follows one. A reference toggle during an active event must leave both the offset and the exit time untouched.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  typedef enum logic [1:0] {
    RSW_IDLE   = 2'd0,
    RSW_ARMED  = 2'd1,
    RSW_ACTIVE = 2'd2
  } rsw_state_e;

  // Arithmetic is done in 32-bit int; phase words up to 30 bits fit.
  function automatic int abs_ps(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Nearest integer of e/p, halves away from zero.
  function automatic int round_div(input int e, input int p);
    int q;
    q = (abs_ps(e) + (p / 2)) / p;
    return (e < 0) ? -q : q;
  endfunction

  // Non-negative remainder of a by m (m >= 1).
  function automatic int wrap_mod(input int a, input int m);
    int r;
    r = a % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  // Phase error left after an edge move of d periods.
  function automatic int resid_ps(input int e, input int d, input int p);
    return e - d * p;
  endfunction

endpackage

// File: rtl/rsw_arm_fsm.sv
module rsw_arm_fsm
  import rsw_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int TRIG_PS = 4000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PHASE_W-1:0] phase_err,
  input  logic                      phase_vld,
  input  logic                      pll_lock,
  input  logic                      ref_sel,
  input  logic                      settle_done,
  output rsw_state_e                state,
  output logic                      pend,
  output logic                      trig,
  output logic                      pick_now,
  output logic                      sel_chg,
  output logic                      step_big
);

  logic       ref_sel_q;
  rsw_state_e state_nx;
  logic       pend_nx;

  assign sel_chg  = (ref_sel != ref_sel_q);
  assign step_big = phase_vld && (abs_ps(int'(phase_err)) > TRIG_PS);
  assign trig     = sel_chg || step_big;
  assign pick_now = phase_vld &&
                    (((state == RSW_ARMED) && trig) ||
                     ((state == RSW_ACTIVE) && pend));

  always_comb begin
    state_nx = state;
    pend_nx  = pend;
    unique case (state)
      RSW_IDLE: begin
        if (pll_lock) state_nx = RSW_ARMED;
      end
      RSW_ARMED: begin
        if (trig) begin
          state_nx = RSW_ACTIVE;
          pend_nx  = !phase_vld;
        end
      end
      RSW_ACTIVE: begin
        if (pick_now) pend_nx = 1'b0;
        if (settle_done) state_nx = RSW_ARMED;
      end
      default: state_nx = RSW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RSW_IDLE;
      pend      <= 1'b0;
      ref_sel_q <= 1'b0;
    end else begin
      state     <= state_nx;
      pend      <= pend_nx;
      ref_sel_q <= ref_sel;
    end
  end

  AST_IDLE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RSW_IDLE && !pll_lock) |=> (state == RSW_IDLE)); // R2

  AST_SEL_TRIGGERS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RSW_ARMED && sel_chg) |=> (state == RSW_ACTIVE)); // R3

  AST_STEP_TRIGGERS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RSW_ARMED && step_big) |=> (state == RSW_ACTIVE)); // R4

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RSW_ACTIVE && !settle_done) |=> (state == RSW_ACTIVE)); // R8

endmodule

// File: rtl/rsw_edge_picker.sv
module rsw_edge_picker
  import rsw_pkg::*;
#(
  parameter int PHASE_W   = 24,
  parameter int M_W       = 9,
  parameter int PERIOD_PS = 1608
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PHASE_W-1:0] phase_err,
  input  logic                      pick_now,
  input  logic [M_W-1:0]            fb_div,
  output logic [M_W-1:0]            edge_ofs,
  output logic signed [PHASE_W-1:0] delta_q
);

  logic [M_W-1:0] m_eff;
  int             step_n;
  int             ofs_nx;

  assign m_eff  = (fb_div == '0) ? M_W'(1) : fb_div;
  assign step_n = round_div(int'(phase_err), PERIOD_PS);
  assign ofs_nx = wrap_mod(int'(edge_ofs) + step_n, int'(m_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_ofs <= '0;
      delta_q  <= '0;
    end else if (pick_now) begin
      edge_ofs <= M_W'(ofs_nx);
      delta_q  <= PHASE_W'(step_n);
    end
  end

  AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_now |=> (edge_ofs < $past(m_eff))); // R6

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_now |=> $stable(edge_ofs)); // R8

endmodule

// File: rtl/rsw_settle_cnt.sv
module rsw_settle_cnt
  import rsw_pkg::*;
#(
  parameter int PHASE_W   = 24,
  parameter int PERIOD_PS = 1608,
  parameter int SETTLE_PS = 2000,
  parameter int SETTLE_N  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PHASE_W-1:0] phase_err,
  input  logic signed [PHASE_W-1:0] delta_q,
  input  logic                      run_en,
  input  logic                      sample_ok,
  output logic                      settle_done
);

  localparam int CNT_W = $clog2(SETTLE_N + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             in_win;

  assign in_win = abs_ps(resid_ps(int'(phase_err), int'(delta_q), PERIOD_PS))
                  <= SETTLE_PS;
  assign settle_done = sample_ok && in_win &&
                       (run_cnt == CNT_W'(SETTLE_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!run_en) begin
      run_cnt <= '0;
    end else if (sample_ok) begin
      run_cnt <= in_win ? run_cnt + 1'b1 : '0;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(SETTLE_N)); // R7

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sample_ok && !in_win) |=> (run_cnt == '0)); // R7

endmodule

// File: rtl/ref_switch_ctrl.sv
module ref_switch_ctrl
  import rsw_pkg::*;
#(
  parameter int PHASE_W   = 24,
  parameter int M_W       = 9,
  parameter int PERIOD_PS = 1608,
  parameter int TRIG_PS   = 4000,
  parameter int SETTLE_PS = 2000,
  parameter int SETTLE_N  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PHASE_W-1:0] phase_err,
  input  logic                      phase_vld,
  input  logic                      pll_lock,
  input  logic                      ref_sel,
  input  logic [M_W-1:0]            fb_div,
  output logic                      narrow_bw,
  output logic [M_W-1:0]            edge_ofs,
  output logic                      armed,
  output logic                      active
);

  rsw_state_e                state;
  logic                      pend;
  logic                      trig;
  logic                      pick_now;
  logic                      sel_chg;
  logic                      step_big;
  logic                      settle_done;
  logic                      sample_ok;
  logic signed [PHASE_W-1:0] delta_q;

  rsw_arm_fsm #(
    .PHASE_W (PHASE_W),
    .TRIG_PS (TRIG_PS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_err   (phase_err),
    .phase_vld   (phase_vld),
    .pll_lock    (pll_lock),
    .ref_sel     (ref_sel),
    .settle_done (settle_done),
    .state       (state),
    .pend        (pend),
    .trig        (trig),
    .pick_now    (pick_now),
    .sel_chg     (sel_chg),
    .step_big    (step_big)
  );

  rsw_edge_picker #(
    .PHASE_W   (PHASE_W),
    .M_W       (M_W),
    .PERIOD_PS (PERIOD_PS)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_err (phase_err),
    .pick_now  (pick_now),
    .fb_div    (fb_div),
    .edge_ofs  (edge_ofs),
    .delta_q   (delta_q)
  );

  assign sample_ok = (state == RSW_ACTIVE) && !pend && phase_vld;

  rsw_settle_cnt #(
    .PHASE_W   (PHASE_W),
    .PERIOD_PS (PERIOD_PS),
    .SETTLE_PS (SETTLE_PS),
    .SETTLE_N  (SETTLE_N)
  ) u_settle (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_err   (phase_err),
    .delta_q     (delta_q),
    .run_en      (state == RSW_ACTIVE),
    .sample_ok   (sample_ok),
    .settle_done (settle_done)
  );

  assign armed     = (state == RSW_ARMED);
  assign active    = (state == RSW_ACTIVE);
  assign narrow_bw = active;

  AST_REARM_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(settle_done)); // R7

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, narrow_bw})); // R5

  AST_PICK_ONLY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pick_now |=> active); // R6

endmodule

// File: tb/tb_ref_switch_ctrl.sv
`timescale 1ns/1ps
module tb_ref_switch_ctrl;

  localparam int PW  = 24;
  localparam int MW  = 9;
  localparam int PER = 1608;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [PW-1:0] phase_err = '0;
  logic                 phase_vld = 1'b0;
  logic                 pll_lock = 1'b0;
  logic                 ref_sel = 1'b0;
  logic [MW-1:0]        fb_div = MW'(32);
  logic                 narrow_bw;
  logic [MW-1:0]        edge_ofs;
  logic                 armed;
  logic                 active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model
  int  m_st = 0;      // 0 disarmed, 1 armed, 2 active
  int  m_ofs = 0;
  int  m_step = 0;
  bit  m_wait = 0;
  int  m_run = 0;
  bit  m_selq = 0;

  ref_switch_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_err (phase_err),
    .phase_vld (phase_vld),
    .pll_lock  (pll_lock),
    .ref_sel   (ref_sel),
    .fb_div    (fb_div),
    .narrow_bw (narrow_bw),
    .edge_ofs  (edge_ofs),
    .armed     (armed),
    .active    (active)
  );

  always #2.5 clk = ~clk;

  function automatic int nearest(input int e);
    int a;
    a = (e < 0) ? -e : e;
    a = (2 * a + PER) / (2 * PER);
    return (e < 0) ? -a : a;
  endfunction

  task automatic do_pick(input int e);
    int m;
    m = (fb_div == 0) ? 1 : int'(fb_div);
    m_step = nearest(e);
    m_ofs  = (((m_ofs + m_step) % m) + m) % m;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ofs = 0; m_step = 0; m_wait = 0; m_run = 0; m_selq = 0;
    end else begin
      int  e;
      bit  chg;
      bit  big;
      e   = int'(phase_err);
      chg = (ref_sel != m_selq);
      big = phase_vld && ((e > 4000) || (e < -4000));
      m_selq = ref_sel;
      if (m_st == 0) begin
        if (pll_lock) m_st = 1;
      end else if (m_st == 1) begin
        if (chg || big) begin
          m_st = 2; m_run = 0;
          if (phase_vld) begin do_pick(e); m_wait = 0; end
          else m_wait = 1;
        end
      end else begin
        if (phase_vld) begin
          if (m_wait) begin do_pick(e); m_wait = 0; end
          else begin
            int r;
            r = e - m_step * PER;
            if (r <= 2000 && r >= -2000) m_run = m_run + 1;
            else m_run = 0;
            if (m_run == 8) begin m_st = 1; m_run = 0; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R5 narrow_bw", int'(narrow_bw), (m_st == 2) ? 1 : 0);
      chk("R2 armed", int'(armed), (m_st == 1) ? 1 : 0);
      chk("R3 active", int'(active), (m_st == 2) ? 1 : 0);
      chk("R6 edge_ofs", int'(edge_ofs), m_ofs);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample(input int e);
    @(negedge clk);
    phase_err = PW'(e);
    phase_vld = 1'b1;
    @(negedge clk);
    phase_vld = 1'b0;
    phase_err = '0;
  endtask

  task automatic toggle_sel();
    @(negedge clk);
    ref_sel = ~ref_sel;
  endtask

  initial begin
    idle(3);
    chk("R1 armed", int'(armed), 0);
    chk("R1 narrow_bw", int'(narrow_bw), 0);
    chk("R1 edge_ofs", int'(edge_ofs), 0);
    rst_n = 1'b1;
    idle(2);
    // R2: no trigger while unlocked
    sample(9000);
    toggle_sel();
    idle(2);
    chk("R2 still disarmed", int'(armed | active), 0);
    @(negedge clk); pll_lock = 1'b1;
    @(negedge clk);
    chk("R2 armed after lock", int'(armed), 1);
    // R4: boundary magnitudes
    sample(4000);
    sample(-4000);
    chk("R4 4000 no trigger", int'(active), 0);
    sample(-4001);
    chk("R4 4001 triggers", int'(active), 1);
    chk("R6 wrap -2 to 30", int'(edge_ofs), 30);
    // R7: runs with gap, restart, inclusive edge
    for (int i = 0; i < 5; i++) sample(-1216);
    idle(3);
    sample(-5217);
    for (int i = 0; i < 7; i++) sample(-3216 + 2000);
    // R8: reference toggle while active ignored
    toggle_sel();
    idle(2);
    chk("R8 ofs kept", int'(edge_ofs), 30);
    chk("R7 not yet settled", int'(active), 1);
    sample(-3216 - 2000);
    chk("R7 armed after run", int'(armed), 1);
    // R3 then half-period pick
    toggle_sel();
    idle(2);
    chk("R3 active on toggle", int'(active), 1);
    sample(804);
    chk("R6 half rounds up", int'(edge_ofs), 31);
    for (int i = 0; i < 8; i++) sample(1608 + 100 * i);
    chk("R7 re-armed", int'(armed), 1);
    // R6 new modulus and negative half
    fb_div = MW'(5);
    sample(-7236);
    chk("R6 -4.5 to -5 mod 5", int'(edge_ofs), 1);
    for (int i = 0; i < 8; i++) sample(-8040);
    sample(9000);
    for (int i = 0; i < 8; i++) sample(9648 - 500);
    fb_div = MW'(0);
    sample(-12000);
    chk("R6 M zero gives 0", int'(edge_ofs), 0);
    for (int i = 0; i < 8; i++) sample(-11256);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule